// File: doc/BRIEF.md
# Delay Line Contention State Tracker

This block keeps the per-slot contention state of an input-buffered, wavelength-routed optical packet buffer. There is one occupancy vector for each input port. Bit `t` of that vector marks that a packet already leaves the port's buffering stage `t` slots from now. There is one availability counter for each pair of output fiber and delay. It holds how many more packets may still leave on that fiber `t` slots from now, from 0 up to the wavelength count `NUM_WL`.

A matching engine outside the block asks whether a packet at input `i`, bound for fiber `j`, may take delay `t`. The answer is yes only when the input's occupancy bit for `t` is clear and the fiber's availability at `t` is non-zero. The engine sends its decisions on a commit bus of several lanes, each carrying an (input, fiber, delay) tuple. A slot-tick strobe marks the end of a slot. In that cycle the block first books the commits and then ages all state by one slot. The delay line with the longest delay becomes free again.

Every read port is a register. Software-free and handshake-free, the block is a small state machine at the heart of a slot scheduler.

Top module: `dl_contention_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, all occupancy bits become 0, every availability field becomes `NUM_WL`, and `q_ok` becomes 0.
- R2: One cycle after a query (`q_in`, `q_fib`, `q_dly`), `q_ok` is 1 exactly when occupancy bit `q_in*NUM_DLY+q_dly` of `occ_vec` is 0 and availability field `q_fib*NUM_DLY+q_dly` of `avail_vec` is non-zero, both taken before that edge.
- R3: An eligible commit on a lane (valid bit set, input bit clear, availability non-zero) sets occupancy bit `in*NUM_DLY+dly` and lowers availability field `fib*NUM_DLY+dly` (bits `[(fib*NUM_DLY+dly)*AV_W +: AV_W]`) by one, visible on the next cycle.
- R4: A commit whose input bit is already set, or whose availability is zero, changes no state.
- R5: Lanes of one cycle are judged in lane order, lane 0 first, each against the state left by the accepted lanes before it. A later lane that repeats an earlier lane's input and delay is dropped. A lane that finds the availability used up by earlier lanes is also dropped.
- R6: On a slot tick every occupancy vector shifts down by one position (bit `t+1` moves to bit `t`), and the top bit becomes 0.
- R7: On a slot tick every availability field of delay `t` takes the value of delay `t+1` of the same fiber, and the field of delay `NUM_DLY-1` is reloaded with `NUM_WL`. No field ever exceeds `NUM_WL`.
- R8: Commits in a tick cycle are booked before the shift: a commit at delay `t` appears at delay `t-1`, and a commit at delay 0 leaves no trace.
- R9: A cycle with neither a tick nor an accepted commit leaves all occupancy and availability state unchanged. Each tick cycle shifts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | End-of-slot strobe; ages state after booking commits |
| cmt_valid | input | NUM_CMT | Per-lane commit valid |
| cmt_in | input | NUM_CMT*IN_W | Per-lane input port index, lane k at bits [k*IN_W +: IN_W] |
| cmt_fib | input | NUM_CMT*FIB_W | Per-lane output fiber index |
| cmt_dly | input | NUM_CMT*DLY_W | Per-lane delay index |
| q_in | input | IN_W | Query input port |
| q_fib | input | FIB_W | Query output fiber |
| q_dly | input | DLY_W | Query delay |
| q_ok | output | 1 | Registered eligibility answer |
| occ_vec | output | NUM_IN*NUM_DLY | Occupancy bits, input i delay t at bit i*NUM_DLY+t |
| avail_vec | output | NUM_FIB*NUM_DLY*AV_W | Availability fields, fiber f delay t at field f*NUM_DLY+t |

## Verification
A lost or extra occupancy bit shows on `occ_vec` in the cycle after the faulty commit. It then walks one position down on every tick until it falls off bit 0, so a wrong shift direction or count shows up within one slot. A miscounted availability shows up in the same way on `avail_vec`. It also turns `q_ok` wrong on the next query at that pair. A top field that is not refilled keeps reporting a stale value for the next `NUM_DLY` ticks. A lane-ordering fault shows only when two lanes meet at the same input or exhaust the same counter, and it leaves one unit of availability too few or too many.

// File: rtl/dlct_pkg.sv
package dlct_pkg;

  // index width for a range of n values, at least one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // counter width able to hold the value n itself
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dlct_commit_filter.sv
module dlct_commit_filter #(
  parameter int NUM_IN  = 8,
  parameter int NUM_FIB = 2,
  parameter int NUM_DLY = 4,
  parameter int NUM_WL  = 4,
  parameter int NUM_CMT = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_CMT-1:0]                    cmt_valid,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_IN)-1:0]  cmt_in,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_FIB)-1:0] cmt_fib,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_DLY)-1:0] cmt_dly,
  input  logic [NUM_IN*NUM_DLY-1:0]             occ_cur,
  input  logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] av_cur,
  output logic [NUM_IN*NUM_DLY-1:0]             occ_cmt,
  output logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] av_cmt
);
  localparam int IN_W  = dlct_pkg::idx_w(NUM_IN);
  localparam int FIB_W = dlct_pkg::idx_w(NUM_FIB);
  localparam int DLY_W = dlct_pkg::idx_w(NUM_DLY);
  localparam int AV_W  = dlct_pkg::cnt_w(NUM_WL);

  // lanes applied one after another; each sees earlier accepted lanes
  always_comb begin
    occ_cmt = occ_cur;
    av_cmt  = av_cur;
    for (int k = 0; k < NUM_CMT; k++) begin
      int ii;
      int ff;
      int dd;
      logic [AV_W-1:0] cur;
      ii  = int'(cmt_in[k*IN_W +: IN_W]);
      ff  = int'(cmt_fib[k*FIB_W +: FIB_W]);
      dd  = int'(cmt_dly[k*DLY_W +: DLY_W]);
      cur = '0;
      if (cmt_valid[k] && ii < NUM_IN && ff < NUM_FIB && dd < NUM_DLY) begin
        cur = av_cmt[(ff*NUM_DLY + dd)*AV_W +: AV_W];
        if (!occ_cmt[ii*NUM_DLY + dd] && cur != '0) begin
          occ_cmt[ii*NUM_DLY + dd] = 1'b1;
          av_cmt[(ff*NUM_DLY + dd)*AV_W +: AV_W] = cur - 1'b1;
        end
      end
    end
  end

  AST_IDLE_BUS_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (cmt_valid == '0) |-> (occ_cmt == occ_cur && av_cmt == av_cur)); // R4

  AST_COMMIT_ONLY_SETS: assert property (@(posedge clk) disable iff (rst)
    ((occ_cmt & occ_cur) == occ_cur)); // R3

endmodule

// File: rtl/dlct_occ_bank.sv
module dlct_occ_bank #(
  parameter int NUM_IN  = 8,
  parameter int NUM_DLY = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      slot_tick,
  input  logic [NUM_IN*NUM_DLY-1:0] occ_cmt,
  output logic [NUM_IN*NUM_DLY-1:0] occ_q
);
  localparam int VW = NUM_DLY;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
    end else if (slot_tick) begin
      for (int i = 0; i < NUM_IN; i++) begin
        occ_q[i*VW +: VW] <= {1'b0, occ_cmt[i*VW+1 +: VW-1]};
      end
    end else begin
      occ_q <= occ_cmt;
    end
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_chk
    AST_OCC_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && occ_cmt[gi*VW +: VW] == occ_q[gi*VW +: VW])
      |=> occ_q[gi*VW +: VW] == ($past(occ_q[gi*VW +: VW]) >> 1)); // R6

    AST_OCC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!slot_tick && occ_cmt[gi*VW +: VW] == occ_q[gi*VW +: VW])
      |=> $stable(occ_q[gi*VW +: VW])); // R9
  end

endmodule

// File: rtl/dlct_avail_bank.sv
module dlct_avail_bank #(
  parameter int NUM_FIB = 2,
  parameter int NUM_DLY = 4,
  parameter int NUM_WL  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_tick,
  input  logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] av_cmt,
  output logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] av_q
);
  localparam int AV_W = dlct_pkg::cnt_w(NUM_WL);
  localparam logic [AV_W-1:0] FULL = AV_W'(NUM_WL);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NUM_FIB*NUM_DLY; e++) begin
        av_q[e*AV_W +: AV_W] <= FULL;
      end
    end else if (slot_tick) begin
      for (int f = 0; f < NUM_FIB; f++) begin
        for (int t = 0; t < NUM_DLY; t++) begin
          if (t == NUM_DLY-1) begin
            av_q[(f*NUM_DLY + t)*AV_W +: AV_W] <= FULL;
          end else begin
            av_q[(f*NUM_DLY + t)*AV_W +: AV_W] <=
              av_cmt[(f*NUM_DLY + t + 1)*AV_W +: AV_W];
          end
        end
      end
    end else begin
      av_q <= av_cmt;
    end
  end

  for (genvar gf = 0; gf < NUM_FIB; gf++) begin : g_fib
    for (genvar gt = 0; gt < NUM_DLY; gt++) begin : g_dly
      localparam int B = (gf*NUM_DLY + gt)*AV_W;

      AST_AV_BOUND: assert property (@(posedge clk) disable iff (rst)
        av_q[B +: AV_W] <= FULL); // R7

      AST_AV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!slot_tick && av_cmt[B +: AV_W] == av_q[B +: AV_W])
        |=> $stable(av_q[B +: AV_W])); // R9

      if (gt == NUM_DLY-1) begin : g_top
        AST_TOP_REFILL: assert property (@(posedge clk) disable iff (rst)
          slot_tick |=> av_q[B +: AV_W] == FULL); // R7
      end
    end
  end

endmodule

// File: rtl/dlct_query.sv
module dlct_query #(
  parameter int NUM_IN  = 8,
  parameter int NUM_FIB = 2,
  parameter int NUM_DLY = 4,
  parameter int NUM_WL  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic [dlct_pkg::idx_w(NUM_IN)-1:0]  q_in,
  input  logic [dlct_pkg::idx_w(NUM_FIB)-1:0] q_fib,
  input  logic [dlct_pkg::idx_w(NUM_DLY)-1:0] q_dly,
  input  logic [NUM_IN*NUM_DLY-1:0]           occ_cur,
  input  logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] av_cur,
  output logic q_ok
);
  localparam int AV_W = dlct_pkg::cnt_w(NUM_WL);

  logic ok_c;
  logic busy_c;

  always_comb begin
    int ii;
    int ff;
    int dd;
    ii     = int'(q_in);
    ff     = int'(q_fib);
    dd     = int'(q_dly);
    ok_c   = 1'b0;
    busy_c = 1'b1;
    if (ii < NUM_IN && ff < NUM_FIB && dd < NUM_DLY) begin
      busy_c = occ_cur[ii*NUM_DLY + dd];
      ok_c   = !busy_c && (av_cur[(ff*NUM_DLY + dd)*AV_W +: AV_W] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_ok <= 1'b0;
    else     q_ok <= ok_c;
  end

  AST_Q_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    busy_c |=> !q_ok); // R2

endmodule

// File: rtl/dl_contention_tracker.sv
module dl_contention_tracker #(
  parameter int NUM_IN  = 8,
  parameter int NUM_FIB = 2,
  parameter int NUM_DLY = 4,
  parameter int NUM_WL  = 4,
  parameter int NUM_CMT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_tick,
  input  logic [NUM_CMT-1:0] cmt_valid,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_IN)-1:0]  cmt_in,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_FIB)-1:0] cmt_fib,
  input  logic [NUM_CMT*dlct_pkg::idx_w(NUM_DLY)-1:0] cmt_dly,
  input  logic [dlct_pkg::idx_w(NUM_IN)-1:0]  q_in,
  input  logic [dlct_pkg::idx_w(NUM_FIB)-1:0] q_fib,
  input  logic [dlct_pkg::idx_w(NUM_DLY)-1:0] q_dly,
  output logic q_ok,
  output logic [NUM_IN*NUM_DLY-1:0] occ_vec,
  output logic [NUM_FIB*NUM_DLY*dlct_pkg::cnt_w(NUM_WL)-1:0] avail_vec
);
  localparam int AV_W = dlct_pkg::cnt_w(NUM_WL);
  localparam int OCC_BITS = NUM_IN*NUM_DLY;
  localparam int AV_BITS  = NUM_FIB*NUM_DLY*AV_W;

  logic [OCC_BITS-1:0] occ_cmt;
  logic [AV_BITS-1:0]  av_cmt;

  dlct_commit_filter #(
    .NUM_IN(NUM_IN), .NUM_FIB(NUM_FIB), .NUM_DLY(NUM_DLY),
    .NUM_WL(NUM_WL), .NUM_CMT(NUM_CMT)
  ) u_filter (
    .clk(clk), .rst(rst),
    .cmt_valid(cmt_valid), .cmt_in(cmt_in), .cmt_fib(cmt_fib), .cmt_dly(cmt_dly),
    .occ_cur(occ_vec), .av_cur(avail_vec),
    .occ_cmt(occ_cmt), .av_cmt(av_cmt)
  );

  dlct_occ_bank #(
    .NUM_IN(NUM_IN), .NUM_DLY(NUM_DLY)
  ) u_occ (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .occ_cmt(occ_cmt), .occ_q(occ_vec)
  );

  dlct_avail_bank #(
    .NUM_FIB(NUM_FIB), .NUM_DLY(NUM_DLY), .NUM_WL(NUM_WL)
  ) u_avail (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .av_cmt(av_cmt), .av_q(avail_vec)
  );

  dlct_query #(
    .NUM_IN(NUM_IN), .NUM_FIB(NUM_FIB), .NUM_DLY(NUM_DLY), .NUM_WL(NUM_WL)
  ) u_query (
    .clk(clk), .rst(rst),
    .q_in(q_in), .q_fib(q_fib), .q_dly(q_dly),
    .occ_cur(occ_vec), .av_cur(avail_vec),
    .q_ok(q_ok)
  );

  AST_POP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> $countones(occ_vec) <= $countones($past(occ_vec)) + NUM_CMT); // R5

endmodule

// File: tb/test_dl_contention_tracker.sv
`timescale 1ns/1ps
module test_dl_contention_tracker;
  localparam int NI = 8;
  localparam int NF = 2;
  localparam int ND = 4;
  localparam int NW = 4;
  localparam int NC = 2;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic [NC-1:0]   cmt_valid = '0;
  logic [NC*3-1:0] cmt_in = '0;
  logic [NC*1-1:0] cmt_fib = '0;
  logic [NC*2-1:0] cmt_dly = '0;
  logic [2:0] q_in = '0;
  logic [0:0] q_fib = '0;
  logic [1:0] q_dly = '0;
  logic q_ok;
  logic [NI*ND-1:0] occ_vec;
  logic [NF*ND*AW-1:0] avail_vec;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dl_contention_tracker #(
    .NUM_IN(NI), .NUM_FIB(NF), .NUM_DLY(ND), .NUM_WL(NW), .NUM_CMT(NC)
  ) i_dl_contention_tracker (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .cmt_valid(cmt_valid), .cmt_in(cmt_in), .cmt_fib(cmt_fib), .cmt_dly(cmt_dly),
    .q_in(q_in), .q_fib(q_fib), .q_dly(q_dly),
    .q_ok(q_ok), .occ_vec(occ_vec), .avail_vec(avail_vec)
  );

  typedef struct packed {
    logic       tick;
    logic       v0;
    logic [2:0] i0;
    logic       f0;
    logic [1:0] d0;
    logic       v1;
    logic [2:0] i1;
    logic       f1;
    logic [1:0] d1;
    logic [2:0] ci;
    logic       cf;
    logic [1:0] cd;
    logic       eo;
    logic [2:0] ea;
  } step_t;

  // one clock per row; after it, check occupancy bit (ci,cd) and availability (cf,cd)
  localparam step_t TBL [12] = '{
    '{1'b0, 1'b1,3'd2,1'b0,2'd1, 1'b0,3'd0,1'b0,2'd0, 3'd2,1'b0,2'd1, 1'b1,3'd3}, // R3
    '{1'b0, 1'b1,3'd2,1'b0,2'd1, 1'b0,3'd0,1'b0,2'd0, 3'd2,1'b0,2'd1, 1'b1,3'd3}, // R4 bit set
    '{1'b0, 1'b1,3'd3,1'b0,2'd1, 1'b1,3'd3,1'b0,2'd1, 3'd3,1'b0,2'd1, 1'b1,3'd2}, // R5 repeat
    '{1'b0, 1'b1,3'd4,1'b0,2'd1, 1'b1,3'd5,1'b0,2'd1, 3'd5,1'b0,2'd1, 1'b1,3'd0}, // R5 two lanes
    '{1'b0, 1'b1,3'd6,1'b0,2'd1, 1'b0,3'd0,1'b0,2'd0, 3'd6,1'b0,2'd1, 1'b0,3'd0}, // R4 avail 0
    '{1'b1, 1'b1,3'd0,1'b1,2'd3, 1'b0,3'd0,1'b0,2'd0, 3'd0,1'b1,2'd2, 1'b1,3'd3}, // R8
    '{1'b0, 1'b0,3'd0,1'b0,2'd0, 1'b0,3'd0,1'b0,2'd0, 3'd2,1'b0,2'd0, 1'b1,3'd0}, // R6 R7
    '{1'b0, 1'b0,3'd0,1'b0,2'd0, 1'b0,3'd0,1'b0,2'd0, 3'd0,1'b1,2'd3, 1'b0,3'd4}, // R7 refill
    '{1'b1, 1'b1,3'd7,1'b1,2'd0, 1'b0,3'd0,1'b0,2'd0, 3'd7,1'b1,2'd0, 1'b0,3'd4}, // R8 delay 0
    '{1'b0, 1'b0,3'd0,1'b0,2'd0, 1'b0,3'd0,1'b0,2'd0, 3'd0,1'b1,2'd1, 1'b1,3'd3}, // R6
    '{1'b1, 1'b1,3'd1,1'b0,2'd3, 1'b1,3'd1,1'b1,2'd2, 3'd1,1'b0,2'd2, 1'b1,3'd3}, // R8 two lanes
    '{1'b0, 1'b0,3'd0,1'b0,2'd0, 1'b0,3'd0,1'b0,2'd0, 3'd1,1'b1,2'd1, 1'b1,3'd3}  // R6 R7
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int occ_at(input int i, input int t);
    return int'(occ_vec[i*ND + t]);
  endfunction

  function automatic int av_at(input int f, input int t);
    return int'(avail_vec[(f*ND + t)*AW +: AW]);
  endfunction

  task automatic idle_inputs();
    slot_tick = 1'b0;
    cmt_valid = '0;
    cmt_in = '0;
    cmt_fib = '0;
    cmt_dly = '0;
  endtask

  task automatic check_clean(input string req);
    chk({req, " occupancy"}, int'(occ_vec == '0), 1);
    for (int f = 0; f < NF; f++)
      for (int t = 0; t < ND; t++)
        chk({req, " availability"}, av_at(f, t), NW);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NI*ND-1:0]    occ_snap;
    logic [NF*ND*AW-1:0] av_snap;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_clean("R1");
    chk("R1 q_ok", int'(q_ok), 0);

    // table walk: drive at a falling edge, check at the next one
    for (int s = 0; s < 12; s++) begin
      slot_tick = TBL[s].tick;
      cmt_valid = {TBL[s].v1, TBL[s].v0};
      cmt_in    = {TBL[s].i1, TBL[s].i0};
      cmt_fib   = {TBL[s].f1, TBL[s].f0};
      cmt_dly   = {TBL[s].d1, TBL[s].d0};
      @(negedge clk);
      chk($sformatf("R3-table row %0d occ", s), occ_at(int'(TBL[s].ci), int'(TBL[s].cd)), int'(TBL[s].eo));
      chk($sformatf("R3-table row %0d avail", s), av_at(int'(TBL[s].cf), int'(TBL[s].cd)), int'(TBL[s].ea));
    end
    idle_inputs();

    // R2 queries on the state left by the table
    q_in = 3'd1; q_fib = 1'b1; q_dly = 2'd1;
    @(negedge clk);
    chk("R2 blocked by input bit", int'(q_ok), 0);
    q_in = 3'd6; q_fib = 1'b0; q_dly = 2'd1;
    @(negedge clk);
    chk("R2 free pair", int'(q_ok), 1);

    // exhaust fiber 1 delay 3 over two cycles, then query it
    cmt_valid = 2'b11; cmt_in = {3'd5, 3'd4}; cmt_fib = 2'b11; cmt_dly = {2'd3, 2'd3};
    @(negedge clk);
    cmt_in = {3'd7, 3'd6};
    @(negedge clk);
    idle_inputs();
    chk("R3 counter reaches zero", av_at(1, 3), 0);
    q_in = 3'd3; q_fib = 1'b1; q_dly = 2'd3;
    @(negedge clk);
    chk("R2 blocked by availability", int'(q_ok), 0);
    chk("R2 input bit clear", occ_at(3, 3), 0);

    // R9 idle cycles leave state alone
    occ_snap = occ_vec;
    av_snap  = avail_vec;
    repeat (3) @(negedge clk);
    chk("R9 occupancy held", int'(occ_vec == occ_snap), 1);
    chk("R9 availability held", int'(avail_vec == av_snap), 1);

    // R9 single tick shifts exactly once
    slot_tick = 1'b1;
    @(negedge clk);
    idle_inputs();
    chk("R9 one shift occ", occ_at(4, 2), 1);
    chk("R9 one shift occ top", occ_at(4, 3), 0);
    chk("R9 one shift avail", av_at(1, 2), 0);

    // R6 R7 drain: NUM_DLY ticks clear everything
    slot_tick = 1'b1;
    repeat (ND) @(negedge clk);
    idle_inputs();
    check_clean("R6 R7 drain");

    // R1 reset in mid-run with a good query and a commit pending
    cmt_valid = 2'b01; cmt_in = {3'd0, 3'd2}; cmt_fib = 2'b00; cmt_dly = {2'd0, 2'd2};
    @(negedge clk);
    idle_inputs();
    chk("R3 commit before reset", occ_at(2, 2), 1);
    q_in = 3'd0; q_fib = 1'b0; q_dly = 2'd0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_clean("R1 mid-run");
    chk("R1 q_ok mid-run", int'(q_ok), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule